// File: doc/BRIEF.md
# ADC Output Demux Formatter

This block sits after a converter channel and turns its stream of samples, one 12-bit code per sampling-clock cycle with over-range indications, into output words on two parallel buses plus a forwarded data clock. In direct mode every sample goes out on the primary bus at the full sample rate. The second bus is then disabled and its output enable is low. In paired mode the samples are grouped two at a time. The earlier sample of each pair goes out on the delayed bus and the later sample on the primary bus, and both buses update on the same edge at half the sample rate.

An over-range input replaces the code with one of the two extreme values, and a flag travels with each word. The forwarded clock runs at half the sample rate in direct mode and at a quarter in paired mode, so each of its edges marks one output word. In paired mode a phase choice places the clock edge either on the data transitions or half-way between them. Mode and phase are taken from their inputs only while reset is asserted, so a pair is never left half-filled.

Top module: `adc_demux_fmt`

## Requirements
- R1: A synchronous active-low reset clears both codes, both flags and the forwarded clock to zero and restarts pairing.
- R2: `paired_sel` and `center_phase` are sampled only on clock edges with reset asserted. Changing them while running has no effect on any output.
- R3: In direct mode (`paired_sel`=0 at reset) the primary bus shows, after each clock edge, the formatted sample presented at that edge. `dly_oe` is 0 and the delayed code and flag stay 0.
- R4: In paired mode (`paired_sel`=1 at reset) `dly_oe` is 1. The first sample after reset is the earlier sample of the first pair. On every second edge both buses update together, with the delayed bus taking the earlier sample and the primary bus the later one. Between those edges both buses hold.
- R5: When `in_ovr_hi` is 1 the output code is 4095 (all ones). When only `in_ovr_lo` is 1 the code is 0. The high indication wins when both are set. Otherwise the raw code passes unchanged.
- R6: Each bus flag is 1 exactly when the sample shown on that bus had either over-range input set.
- R7: In direct mode the forwarded clock toggles on every clock edge, and is 1 after the first edge following reset.
- R8: In paired mode with edge phase (`center_phase`=0 at reset) the forwarded clock toggles only on the edges that update the buses, giving a quarter-rate clock.
- R9: In paired mode with centre phase (`center_phase`=1 at reset) the forwarded clock toggles only on the edges between bus updates, starting with the first edge after reset.
- R10: In direct mode the phase setting has no effect on the forwarded clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also captures mode and phase |
| paired_sel | input | 1 | 1 selects paired (1:2) mode, 0 direct mode |
| center_phase | input | 1 | 1 places the forwarded clock edge mid-word in paired mode |
| in_code | input | 12 | Raw sample code |
| in_ovr_hi | input | 1 | Sample is above positive full scale |
| in_ovr_lo | input | 1 | Sample is below negative full scale |
| pri_code | output | 12 | Primary bus code |
| pri_ovr | output | 1 | Over-range flag of the primary word |
| dly_code | output | 12 | Delayed bus code |
| dly_ovr | output | 1 | Over-range flag of the delayed word |
| dly_oe | output | 1 | Delayed bus output enable |
| dclk_out | output | 1 | Forwarded data clock |

## Verification
A wrong pairing slot shows at once in paired mode. The two buses swap their samples, or they update on the wrong edge, within two clock cycles. Because the slot also drives the forwarded clock, the same fault moves a clock toggle to the opposite edge. A corrupted latched mode shows up on `dly_oe` and on the forwarded clock rate on the first edge after reset. A fault in over-range forcing shows on the first over-range sample, one or two cycles after it enters. The bench compares every output on every cycle, so each of these faults is reported within two cycles of its cause.

// File: rtl/adc_fmt_pkg.sv
// Shared types of the ADC output formatter.
// Assumes: one-bit encodings; the encoding values are used by the checker.
package adc_fmt_pkg;
    typedef enum logic {
        FMT_DIRECT = 1'b0,
        FMT_PAIRED = 1'b1
    } fmt_mode_e;

    typedef enum logic {
        PH_EDGE   = 1'b0,
        PH_CENTER = 1'b1
    } fmt_phase_e;
endpackage

// File: rtl/adc_fmt_cfg.sv
// Captures the output mode and clock phase while reset is asserted and
// holds them afterwards.
// Assumes: mode inputs are stable during the reset cycles.
module adc_fmt_cfg
    import adc_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       paired_req,
    input  logic       center_req,
    output fmt_mode_e  mode_q,
    output fmt_phase_e phase_q
);
    // Load configuration only during reset; hold it while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= paired_req ? FMT_PAIRED : FMT_DIRECT;
            phase_q <= center_req ? PH_CENTER : PH_EDGE;
        end
    end
endmodule

// File: rtl/adc_fmt_clamp.sv
// Forces the code to a full-scale extreme on over-range and forms the flag.
// Assumes: the high indication has priority when both are set.
module adc_fmt_clamp #(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] raw_code,
    input  logic              ovr_hi,
    input  logic              ovr_lo,
    output logic [CODE_W-1:0] fmt_code,
    output logic              fmt_ovr
);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;
    localparam logic [CODE_W-1:0] CODE_BOT = '0;

    // Select the forced or raw code.
    always_comb begin
        if (ovr_hi)      fmt_code = CODE_TOP;
        else if (ovr_lo) fmt_code = CODE_BOT;
        else             fmt_code = raw_code;
        fmt_ovr = ovr_hi | ovr_lo;
    end
endmodule

// File: rtl/adc_fmt_pair.sv
// Routes formatted samples to the primary and delayed buses.
// Direct mode: primary updates every edge, delayed bus held at zero.
// Paired mode: even slot samples wait in a holding register, odd slot
// samples release the pair onto both buses at once.
// Assumes: mode is constant outside reset.
module adc_fmt_pair
    import adc_fmt_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_mode_e         mode,
    input  logic [CODE_W-1:0] s_code,
    input  logic              s_ovr,
    output logic              second_q,
    output logic [CODE_W-1:0] pri_code,
    output logic              pri_ovr,
    output logic [CODE_W-1:0] dly_code,
    output logic              dly_ovr
);
    typedef struct packed {
        logic              ovr;
        logic [CODE_W-1:0] code;
    } word_t;

    word_t in_w, hold_q, pri_q, dly_q;

    assign in_w = '{ovr: s_ovr, code: s_code};

    // Track which half of a pair the incoming sample fills.
    always_ff @(posedge clk) begin
        if (!rst_n)                  second_q <= 1'b0;
        else if (mode == FMT_PAIRED) second_q <= ~second_q;
        else                         second_q <= 1'b0;
    end

    // Keep the earlier sample of a pair until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  hold_q <= '0;
        else if (mode == FMT_PAIRED && !second_q)    hold_q <= in_w;
    end

    // Update the output words according to the mode and slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '0;
            dly_q <= '0;
        end else if (mode == FMT_DIRECT) begin
            pri_q <= in_w;
            dly_q <= '0;
        end else if (second_q) begin
            pri_q <= in_w;
            dly_q <= hold_q;
        end
    end

    assign pri_code = pri_q.code;
    assign pri_ovr  = pri_q.ovr;
    assign dly_code = dly_q.code;
    assign dly_ovr  = dly_q.ovr;
endmodule

// File: rtl/adc_fmt_dclk.sv
// Forwarded data clock divider.
// Direct mode toggles every edge. Paired mode toggles every second edge,
// on the update edges for edge phase and on the others for centre phase.
// Assumes: second_q is the slot of the sample taken at the current edge.
module adc_fmt_dclk
    import adc_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fmt_mode_e  mode,
    input  fmt_phase_e phase,
    input  logic       second_q,
    output logic       dclk_q
);
    logic flip;

    // Decide whether this edge toggles the forwarded clock.
    always_comb begin
        if (mode == FMT_DIRECT)    flip = 1'b1;
        else if (phase == PH_EDGE) flip = second_q;
        else                       flip = ~second_q;
    end

    // Divider register, low out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    dclk_q <= 1'b0;
        else if (flip) dclk_q <= ~dclk_q;
    end
endmodule

// File: rtl/adc_demux_fmt.sv
// ADC output formatter top: over-range forcing, direct or paired bus
// routing, and a forwarded data clock with selectable phase.
// Assumes: one sample per clk edge; mode and phase change only in reset.
module adc_demux_fmt
    import adc_fmt_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paired_sel,
    input  logic              center_phase,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_ovr_hi,
    input  logic              in_ovr_lo,
    output logic [CODE_W-1:0] pri_code,
    output logic              pri_ovr,
    output logic [CODE_W-1:0] dly_code,
    output logic              dly_ovr,
    output logic              dly_oe,
    output logic              dclk_out
);
    fmt_mode_e         mode_q;
    fmt_phase_e        phase_q;
    logic [CODE_W-1:0] f_code;
    logic              f_ovr;
    logic              second_q;

    adc_fmt_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .paired_req (paired_sel),
        .center_req (center_phase),
        .mode_q     (mode_q),
        .phase_q    (phase_q)
    );

    adc_fmt_clamp #(.CODE_W(CODE_W)) u_clamp (
        .raw_code (in_code),
        .ovr_hi   (in_ovr_hi),
        .ovr_lo   (in_ovr_lo),
        .fmt_code (f_code),
        .fmt_ovr  (f_ovr)
    );

    adc_fmt_pair #(.CODE_W(CODE_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .s_code   (f_code),
        .s_ovr    (f_ovr),
        .second_q (second_q),
        .pri_code (pri_code),
        .pri_ovr  (pri_ovr),
        .dly_code (dly_code),
        .dly_ovr  (dly_ovr)
    );

    adc_fmt_dclk u_dclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .phase    (phase_q),
        .second_q (second_q),
        .dclk_q   (dclk_out)
    );

    // The delayed bus drives only in paired mode.
    assign dly_oe = (mode_q == FMT_PAIRED);
endmodule

// File: rtl/adc_demux_fmt_chk.sv
// Port-level properties of the formatter, bound to the top module.
module adc_demux_fmt_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] pri_code,
    input logic              pri_ovr,
    input logic [CODE_W-1:0] dly_code,
    input logic              dly_ovr,
    input logic              dly_oe,
    input logic              dclk_out
);
    localparam logic [CODE_W-1:0] TOP = '1;

    // R1: reset clears every output word and the clock.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pri_code == '0 && dly_code == '0 && !pri_ovr && !dly_ovr && !dclk_out));

    // R2: configuration does not change while running.
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(dly_oe));

    // R3: delayed bus stays zero when disabled.
    a_r3_dly_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_oe |-> (dly_code == '0 && !dly_ovr));

    // R4: in paired mode the buses never change on consecutive edges.
    a_r4_pair_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_oe && $past(rst_n) && (pri_code != $past(pri_code) || dly_code != $past(dly_code)))
        |-> ($past(pri_code) == $past(pri_code, 2) && $past(dly_code) == $past(dly_code, 2)));

    // R5: a flagged word carries an extreme code.
    a_r5_pri_extreme: assert property (@(posedge clk) disable iff (!rst_n)
        pri_ovr |-> (pri_code == '0 || pri_code == TOP));
    a_r5_dly_extreme: assert property (@(posedge clk) disable iff (!rst_n)
        dly_ovr |-> (dly_code == '0 || dly_code == TOP));

    // R7: direct mode clock toggles on every edge.
    a_r7_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly_oe && $past(rst_n)) |-> (dclk_out != $past(dclk_out)));

    // R8 / R9: paired mode clock never toggles on two edges in a row.
    a_r8_quarter_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_oe && $past(rst_n) && dclk_out != $past(dclk_out))
        |-> ($past(dclk_out) == $past(dclk_out, 2)));
endmodule

bind adc_demux_fmt adc_demux_fmt_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri_code (pri_code),
    .pri_ovr  (pri_ovr),
    .dly_code (dly_code),
    .dly_ovr  (dly_ovr),
    .dly_oe   (dly_oe),
    .dclk_out (dclk_out)
);

// File: tb/sim_adc_demux_fmt.sv
// Bench for the formatter: directed over-range corners plus random samples
// from a fixed seed, compared every cycle with a behavioural model.
module sim_adc_demux_fmt;
    localparam int CODE_W = 12;
    localparam logic [CODE_W-1:0] TOPC = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              paired_sel = 1'b0;
    logic              center_phase = 1'b0;
    logic [CODE_W-1:0] in_code = '0;
    logic              in_ovr_hi = 1'b0;
    logic              in_ovr_lo = 1'b0;
    logic [CODE_W-1:0] pri_code, dly_code;
    logic              pri_ovr, dly_ovr, dly_oe, dclk_out;

    adc_demux_fmt #(.CODE_W(CODE_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .paired_sel   (paired_sel),
        .center_phase (center_phase),
        .in_code      (in_code),
        .in_ovr_hi    (in_ovr_hi),
        .in_ovr_lo    (in_ovr_lo),
        .pri_code     (pri_code),
        .pri_ovr      (pri_ovr),
        .dly_code     (dly_code),
        .dly_ovr      (dly_ovr),
        .dly_oe       (dly_oe),
        .dclk_out     (dclk_out)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string prev_tag = "R1";

    // Model state: expected outputs after the latest edge.
    bit                m_mode, m_ph, m_odd;
    logic [CODE_W-1:0] m_hold, e_pri, e_dly;
    logic              m_hold_ovr, e_pri_ovr, e_dly_ovr, e_dclk;

    function automatic logic [CODE_W-1:0] fmt_code(logic [CODE_W-1:0] c, logic hi, logic lo);
        if (hi)      return TOPC;
        else if (lo) return '0;
        else         return c;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Advance the model over the coming rising edge using the driven inputs.
    task automatic model_edge();
        logic [CODE_W-1:0] fc;
        logic fo;
        fc = fmt_code(in_code, in_ovr_hi, in_ovr_lo);
        fo = in_ovr_hi | in_ovr_lo;
        if (!rst_n) begin
            m_mode = paired_sel; m_ph = center_phase; m_odd = 1'b0;
            m_hold = '0; m_hold_ovr = 1'b0;
            e_pri = '0; e_pri_ovr = 1'b0; e_dly = '0; e_dly_ovr = 1'b0; e_dclk = 1'b0;
        end else if (!m_mode) begin
            e_pri = fc; e_pri_ovr = fo; e_dly = '0; e_dly_ovr = 1'b0;
            e_dclk = ~e_dclk;
        end else if (!m_odd) begin
            m_hold = fc; m_hold_ovr = fo;
            if (m_ph) e_dclk = ~e_dclk;
            m_odd = 1'b1;
        end else begin
            e_dly = m_hold; e_dly_ovr = m_hold_ovr; e_pri = fc; e_pri_ovr = fo;
            if (!m_ph) e_dclk = ~e_dclk;
            m_odd = 1'b0;
        end
    endtask

    task automatic check_all(string dtag);
        string ftag, ctag;
        ftag = (dtag == "R1") ? "R1" : "R6";
        if (dtag == "R1")  ctag = "R1";
        else if (!m_mode)  ctag = m_ph ? "R10" : "R7";
        else               ctag = m_ph ? "R9" : "R8";
        chk(dtag, "pri_code", 32'(pri_code), 32'(e_pri));
        chk(dtag, "dly_code", 32'(dly_code), 32'(e_dly));
        chk(ftag, "pri_ovr", 32'(pri_ovr), 32'(e_pri_ovr));
        chk(ftag, "dly_ovr", 32'(dly_ovr), 32'(e_dly_ovr));
        chk((dtag == "R1") ? "R1" : (m_mode ? "R4" : "R3"), "dly_oe", 32'(dly_oe), 32'(m_mode));
        chk(ctag, "dclk_out", 32'(dclk_out), 32'(e_dclk));
    endtask

    // One sample period: check the last edge, then drive the next sample.
    task automatic cycle(string dtag, logic rst, logic [CODE_W-1:0] c, logic hi, logic lo);
        @(negedge clk);
        check_all(prev_tag);
        prev_tag  = dtag;
        rst_n     = rst;
        in_code   = c;
        in_ovr_hi = hi;
        in_ovr_lo = lo;
        model_edge();
    endtask

    task automatic rand_cycle(string dtag);
        int r;
        r = int'($urandom % 16);
        cycle(dtag, 1'b1, CODE_W'($urandom), r == 0, r == 1);
    endtask

    task automatic run_cfg(bit pm, bit ph);
        paired_sel = pm;
        center_phase = ph;
        for (int i = 0; i < 3; i++) cycle("R1", 1'b0, CODE_W'($urandom), 1'b0, 1'b0);
        // R5 corners: high with zero raw, low alone, both set, low with top raw.
        cycle("R5", 1'b1, '0, 1'b1, 1'b0);
        cycle("R5", 1'b1, 12'hABC, 1'b0, 1'b1);
        cycle("R5", 1'b1, 12'h123, 1'b1, 1'b1);
        cycle("R5", 1'b1, TOPC, 1'b0, 1'b1);
        cycle("R5", 1'b1, 12'h5A5, 1'b0, 1'b0);
        for (int i = 0; i < 150; i++) rand_cycle(pm ? "R4" : "R3");
        // R2: flip both configuration inputs while running.
        paired_sel = ~pm;
        center_phase = ~ph;
        for (int i = 0; i < 40; i++) rand_cycle("R2");
        paired_sel = pm;
        center_phase = ph;
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        model_edge();
        run_cfg(1'b0, 1'b0);
        run_cfg(1'b0, 1'b1);
        run_cfg(1'b1, 1'b0);
        run_cfg(1'b1, 1'b1);
        cycle("R1", 1'b0, '0, 1'b0, 1'b0);
        @(negedge clk);
        check_all(prev_tag);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule